// File: doc/BRIEF.md
# Security interrupt status collector

This block gathers the security-violation interrupt lines raised by the memory protection controllers, the peripheral protection controllers and the expansion master security controllers of a subsystem. It presents them as status words behind a simple 32-bit register bus. Software uses enable and write-one-to-clear registers to control them.

The block does not only clear its own copies of interrupt state. It forwards each peripheral controller's status and enable bits back to that controller as dedicated clear and enable lines. A word written to the master clear register goes straight onto per-controller clear lines. Only the master-security sources are merged, through their enable mask, into one interrupt output. The bus completes every access in the cycle it is presented. Reads are combinational from the address. Writes take effect at the next rising clock edge, and only full-word writes have any effect.

Top module: `sec_irq_collector`

## Requirements
- R1: The word at offset 0x1C is read-only. It returns the memory-controller inputs as they were sampled at the most recent clock edge. Internal sources sit at bits 0 and up, expansion sources at bits 16 and up, and all other bits read 0.
- R2: The peripheral status word at 0x20 uses fixed bit positions: internal APB controllers on bits 0 and 1, APB expansion controllers on bits 4 to 7, AHB expansion controllers on bits 20 to 23. A bit is set at any clock edge where its input is high. It stays set after the input falls.
- R3: A full-word write to 0x24 clears each peripheral status bit written as 1. If a source input is high in the same cycle, that bit stays set.
- R4: The peripheral enable word at 0x28 stores only the bits in mask 0x00F000F3 and reads back masked.
- R5: Each peripheral controller's clear output equals its own status bit, and its enable output equals its own enable bit.
- R6: The master status word at 0x30 returns the master inputs sampled at the last clock edge on bits 16 and up. The master enable word at 0x38 stores only bits 16 to 16+N-1.
- R7: msc_irq_o is high exactly when the master status and the master enable share a set bit.
- R8: A full-word write to 0x34 is not stored as a register. Its bits 16 and up appear on msc_clr_o after the write edge and hold until the next such write. Reading 0x34 returns 0.
- R9: Bridge status at 0x40 always reads 0. A write to 0x44 has no effect. The bridge enable at 0x48 stores only bits 31:16.
- R10: Status words ignore writes. The clear words 0x24, 0x34 and 0x44 read 0. Undefined offsets read 0 and ignore writes.
- R11: A write whose size code is not word (bus_size_i other than 2; 0 is byte, 1 is halfword) changes no state.
- R12: After reset, the peripheral status, peripheral enable, master enable, master clear and bridge enable are all zero, and so are all clear, enable and interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| mpc_irq_i | input | N_MPC | Internal memory-controller interrupt levels |
| mpc_exp_irq_i | input | N_MPC_EXP | Expansion memory-controller interrupt levels |
| ppc_apb_irq_i | input | N_APB | Internal APB peripheral-controller interrupts |
| ppc_apbx_irq_i | input | N_APBX | APB expansion peripheral-controller interrupts |
| ppc_ahbx_irq_i | input | N_AHBX | AHB expansion peripheral-controller interrupts |
| ppc_apb_clr_o | output | N_APB | Clear lines to internal APB controllers |
| ppc_apb_en_o | output | N_APB | Enable lines to internal APB controllers |
| ppc_apbx_clr_o | output | N_APBX | Clear lines to APB expansion controllers |
| ppc_apbx_en_o | output | N_APBX | Enable lines to APB expansion controllers |
| ppc_ahbx_clr_o | output | N_AHBX | Clear lines to AHB expansion controllers |
| ppc_ahbx_en_o | output | N_AHBX | Enable lines to AHB expansion controllers |
| msc_exp_irq_i | input | N_MSC | Expansion master-controller interrupt levels |
| msc_clr_o | output | N_MSC | Clear lines to master controllers |
| msc_irq_o | output | 1 | Combined master-security interrupt |

## Verification
The bench checks the sparse placement of peripheral sources with a single one-cycle pulse. Wrong placement would show a bit at the wrong position or lose a bit in the gaps. It raises a source in the same cycle as a clear write on that bit; a design that lets the clear win would read the bit back as zero. Narrow writes are aimed at the enable and master clear words; a design that ignores the size would change the enable readback or the clear lines. Writes to status words and undefined offsets are checked as well; a design that stores them would show altered readback.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned APBX_BASE = 4;
  localparam int unsigned AHBX_BASE = 20;
  localparam int unsigned EXP_BASE  = 16;

  localparam logic [11:0] OFS_MPC_STAT = 12'h01C;
  localparam logic [11:0] OFS_PPC_STAT = 12'h020;
  localparam logic [11:0] OFS_PPC_CLR  = 12'h024;
  localparam logic [11:0] OFS_PPC_EN   = 12'h028;
  localparam logic [11:0] OFS_MSC_STAT = 12'h030;
  localparam logic [11:0] OFS_MSC_CLR  = 12'h034;
  localparam logic [11:0] OFS_MSC_EN   = 12'h038;
  localparam logic [11:0] OFS_BRG_STAT = 12'h040;
  localparam logic [11:0] OFS_BRG_CLR  = 12'h044;
  localparam logic [11:0] OFS_BRG_EN   = 12'h048;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} bus_size_e;

  // flat index (apb, then apbx, then ahbx) -> bit in peripheral status word
  function automatic int unsigned ppc_bit(int unsigned k, int unsigned n_apb, int unsigned n_apbx);
    if (k < n_apb) return k;
    else if (k < n_apb + n_apbx) return APBX_BASE + (k - n_apb);
    else return AHBX_BASE + (k - n_apb - n_apbx);
  endfunction
endpackage

// File: rtl/sic_sticky_bank.sv
module sic_sticky_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/sic_ppc_ctrl.sv
module sic_ppc_ctrl #(
  parameter int unsigned N_APB  = 2,
  parameter int unsigned N_APBX = 4,
  parameter int unsigned N_AHBX = 4,
  localparam int unsigned NT    = N_APB + N_APBX + N_AHBX
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NT-1:0] irq_i,
  input  logic          wr_clr_i,
  input  logic          wr_en_i,
  input  logic [31:0]   wdata_i,
  output logic [NT-1:0] stat_o,
  output logic [NT-1:0] en_o,
  output logic [31:0]   stat_word_o,
  output logic [31:0]   en_word_o
);
  logic [NT-1:0] clr_mask, en_wr, en_q;

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      clr_mask[k] = wr_clr_i & wdata_i[sic_pkg::ppc_bit(k, N_APB, N_APBX)];
      en_wr[k]    = wdata_i[sic_pkg::ppc_bit(k, N_APB, N_APBX)];
    end
  end

  sic_sticky_bank #(.W(NT)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_i),
    .clr_i  (clr_mask),
    .stat_o (stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_en_i) en_q <= en_wr;
  end

  assign en_o = en_q;

  always_comb begin
    stat_word_o = '0;
    en_word_o   = '0;
    for (int k = 0; k < NT; k++) begin
      stat_word_o[sic_pkg::ppc_bit(k, N_APB, N_APBX)] = stat_o[k];
      en_word_o[sic_pkg::ppc_bit(k, N_APB, N_APBX)]   = en_q[k];
    end
  end
endmodule

// File: rtl/sic_msc_ctrl.sv
module sic_msc_ctrl #(
  parameter int unsigned N_MSC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MSC-1:0] irq_i,
  input  logic             wr_clr_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wdata_i,
  output logic [N_MSC-1:0] clr_o,
  output logic             irq_o,
  output logic [31:0]      stat_word_o,
  output logic [31:0]      en_word_o
);
  localparam int unsigned B = sic_pkg::EXP_BASE;
  logic [N_MSC-1:0] stat_q, en_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      clr_q  <= '0;
    end else begin
      stat_q <= irq_i;
      if (wr_en_i)  en_q  <= wdata_i[B +: N_MSC];
      if (wr_clr_i) clr_q <= wdata_i[B +: N_MSC];
    end
  end

  assign clr_o = clr_q;
  assign irq_o = |(stat_q & en_q);

  always_comb begin
    stat_word_o = '0;
    en_word_o   = '0;
    stat_word_o[B +: N_MSC] = stat_q;
    en_word_o[B +: N_MSC]   = en_q;
  end
endmodule

// File: rtl/sec_irq_collector.sv
module sec_irq_collector #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned N_MPC     = 4,
  parameter int unsigned N_MPC_EXP = 4,
  parameter int unsigned N_APB     = 2,
  parameter int unsigned N_APBX    = 4,
  parameter int unsigned N_AHBX    = 4,
  parameter int unsigned N_MSC     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_we_i,
  input  logic [1:0]           bus_size_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [N_MPC-1:0]     mpc_irq_i,
  input  logic [N_MPC_EXP-1:0] mpc_exp_irq_i,
  input  logic [N_APB-1:0]     ppc_apb_irq_i,
  input  logic [N_APBX-1:0]    ppc_apbx_irq_i,
  input  logic [N_AHBX-1:0]    ppc_ahbx_irq_i,
  output logic [N_APB-1:0]     ppc_apb_clr_o,
  output logic [N_APB-1:0]     ppc_apb_en_o,
  output logic [N_APBX-1:0]    ppc_apbx_clr_o,
  output logic [N_APBX-1:0]    ppc_apbx_en_o,
  output logic [N_AHBX-1:0]    ppc_ahbx_clr_o,
  output logic [N_AHBX-1:0]    ppc_ahbx_en_o,
  input  logic [N_MSC-1:0]     msc_exp_irq_i,
  output logic [N_MSC-1:0]     msc_clr_o,
  output logic                 msc_irq_o
);
  import sic_pkg::*;

  localparam int unsigned NT = N_APB + N_APBX + N_AHBX;

  logic [ADDR_W-1:0] word_addr;
  logic              wr_ok;
  logic [N_MPC-1:0]     mpc_q;
  logic [N_MPC_EXP-1:0] mpcx_q;
  logic [15:0]          brg_en_q;
  logic [NT-1:0]        ppc_stat, ppc_en;
  logic [31:0]          ppc_stat_w, ppc_en_w, msc_stat_w, msc_en_w, mpc_w;

  assign word_addr = {bus_addr_i[ADDR_W-1:2], 2'b00};
  assign wr_ok     = bus_we_i && (bus_size_i == SZ_WORD);

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpc_q    <= '0;
      mpcx_q   <= '0;
      brg_en_q <= '0;
    end else begin
      mpc_q  <= mpc_irq_i;
      mpcx_q <= mpc_exp_irq_i;
      if (wr_ok && hit(word_addr, OFS_BRG_EN)) brg_en_q <= bus_wdata_i[31:16];
    end
  end

  always_comb begin
    mpc_w = '0;
    mpc_w[N_MPC-1:0]           = mpc_q;
    mpc_w[EXP_BASE +: N_MPC_EXP] = mpcx_q;
  end

  sic_ppc_ctrl #(.N_APB(N_APB), .N_APBX(N_APBX), .N_AHBX(N_AHBX)) u_ppc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       ({ppc_ahbx_irq_i, ppc_apbx_irq_i, ppc_apb_irq_i}),
    .wr_clr_i    (wr_ok && hit(word_addr, OFS_PPC_CLR)),
    .wr_en_i     (wr_ok && hit(word_addr, OFS_PPC_EN)),
    .wdata_i     (bus_wdata_i),
    .stat_o      (ppc_stat),
    .en_o        (ppc_en),
    .stat_word_o (ppc_stat_w),
    .en_word_o   (ppc_en_w)
  );

  assign {ppc_ahbx_clr_o, ppc_apbx_clr_o, ppc_apb_clr_o} = ppc_stat;
  assign {ppc_ahbx_en_o,  ppc_apbx_en_o,  ppc_apb_en_o}  = ppc_en;

  sic_msc_ctrl #(.N_MSC(N_MSC)) u_msc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (msc_exp_irq_i),
    .wr_clr_i    (wr_ok && hit(word_addr, OFS_MSC_CLR)),
    .wr_en_i     (wr_ok && hit(word_addr, OFS_MSC_EN)),
    .wdata_i     (bus_wdata_i),
    .clr_o       (msc_clr_o),
    .irq_o       (msc_irq_o),
    .stat_word_o (msc_stat_w),
    .en_word_o   (msc_en_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    if      (hit(word_addr, OFS_MPC_STAT)) bus_rdata_o = mpc_w;
    else if (hit(word_addr, OFS_PPC_STAT)) bus_rdata_o = ppc_stat_w;
    else if (hit(word_addr, OFS_PPC_EN))   bus_rdata_o = ppc_en_w;
    else if (hit(word_addr, OFS_MSC_STAT)) bus_rdata_o = msc_stat_w;
    else if (hit(word_addr, OFS_MSC_EN))   bus_rdata_o = msc_en_w;
    else if (hit(word_addr, OFS_BRG_EN))   bus_rdata_o = {brg_en_q, 16'h0000};
  end
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned N_MPC     = 4,
  parameter int unsigned N_MPC_EXP = 4,
  parameter int unsigned N_APB     = 2,
  parameter int unsigned N_APBX    = 4,
  parameter int unsigned N_AHBX    = 4,
  parameter int unsigned N_MSC     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic                 bus_we_i,
  input logic [1:0]           bus_size_i,
  input logic [31:0]          bus_rdata_o,
  input logic [N_MPC-1:0]     mpc_irq_i,
  input logic [N_MPC_EXP-1:0] mpc_exp_irq_i,
  input logic [N_APB+N_APBX+N_AHBX-1:0] ppc_irq_all,
  input logic [N_APB+N_APBX+N_AHBX-1:0] ppc_clr_all,
  input logic [N_APB+N_APBX+N_AHBX-1:0] ppc_en_all,
  input logic [N_MSC-1:0]     msc_exp_irq_i,
  input logic [N_MSC-1:0]     msc_clr_o,
  input logic                 msc_irq_o
);
  localparam int unsigned NT = N_APB + N_APBX + N_AHBX;

  logic                 past_ok;
  logic [N_MPC-1:0]     mpc_prev;
  logic [N_MPC_EXP-1:0] mpcx_prev;
  logic [NT-1:0]        ppc_prev;
  logic [N_MSC-1:0]     msc_prev;
  logic [31:0]          mpc_exp_word;
  logic [ADDR_W-1:0]    wa;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok   <= 1'b0;
      mpc_prev  <= '0;
      mpcx_prev <= '0;
      ppc_prev  <= '0;
      msc_prev  <= '0;
    end else begin
      past_ok   <= 1'b1;
      mpc_prev  <= mpc_irq_i;
      mpcx_prev <= mpc_exp_irq_i;
      ppc_prev  <= ppc_irq_all;
      msc_prev  <= msc_exp_irq_i;
    end
  end

  always_comb begin
    mpc_exp_word = '0;
    mpc_exp_word[N_MPC-1:0] = mpc_prev;
    mpc_exp_word[16 +: N_MPC_EXP] = mpcx_prev;
  end

  assign wa = {bus_addr_i[ADDR_W-1:2], 2'b00};

  a_r1_mpc_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && wa == ADDR_W'(12'h01C)) |-> bus_rdata_o == mpc_exp_word);

  a_r2_ppc_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (ppc_clr_all & ppc_prev) == ppc_prev);

  a_r7_msc_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && msc_prev == '0) |-> !msc_irq_o);

  a_r9_bridge_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa == ADDR_W'(12'h040)) |-> bus_rdata_o == 32'h0);

  a_r10_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa == ADDR_W'(12'h024) || wa == ADDR_W'(12'h034) || wa == ADDR_W'(12'h044))
      |-> bus_rdata_o == 32'h0);

  a_r11_narrow_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_size_i != 2'd2) |=> ($stable(ppc_en_all) && $stable(msc_clr_o)));
endmodule

bind sec_irq_collector sic_checker #(
  .ADDR_W(ADDR_W), .N_MPC(N_MPC), .N_MPC_EXP(N_MPC_EXP),
  .N_APB(N_APB), .N_APBX(N_APBX), .N_AHBX(N_AHBX), .N_MSC(N_MSC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_addr_i    (bus_addr_i),
  .bus_we_i      (bus_we_i),
  .bus_size_i    (bus_size_i),
  .bus_rdata_o   (bus_rdata_o),
  .mpc_irq_i     (mpc_irq_i),
  .mpc_exp_irq_i (mpc_exp_irq_i),
  .ppc_irq_all   ({ppc_ahbx_irq_i, ppc_apbx_irq_i, ppc_apb_irq_i}),
  .ppc_clr_all   ({ppc_ahbx_clr_o, ppc_apbx_clr_o, ppc_apb_clr_o}),
  .ppc_en_all    ({ppc_ahbx_en_o, ppc_apbx_en_o, ppc_apb_en_o}),
  .msc_exp_irq_i (msc_exp_irq_i),
  .msc_clr_o     (msc_clr_o),
  .msc_irq_o     (msc_irq_o)
);

// File: tb/sec_irq_collector_bench.sv
module sec_irq_collector_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr = '0;
  logic        we = 0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  mpc = '0, mpcx = '0;
  logic [1:0]  apb = '0;
  logic [3:0]  apbx = '0, ahbx = '0;
  logic [1:0]  apb_clr, apb_en;
  logic [3:0]  apbx_clr, apbx_en, ahbx_clr, ahbx_en;
  logic [3:0]  msc = '0, msc_clr;
  logic        msc_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_irq_collector u_sec_irq_collector (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(addr), .bus_we_i(we), .bus_size_i(size),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mpc_irq_i(mpc), .mpc_exp_irq_i(mpcx),
    .ppc_apb_irq_i(apb), .ppc_apbx_irq_i(apbx), .ppc_ahbx_irq_i(ahbx),
    .ppc_apb_clr_o(apb_clr), .ppc_apb_en_o(apb_en),
    .ppc_apbx_clr_o(apbx_clr), .ppc_apbx_en_o(apbx_en),
    .ppc_ahbx_clr_o(ahbx_clr), .ppc_ahbx_en_o(ahbx_en),
    .msc_exp_irq_i(msc), .msc_clr_o(msc_clr), .msc_irq_o(msc_irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    @(negedge clk);
    addr = a; wdata = d; size = sz; we = 1;
    @(negedge clk);
    we = 0; size = 2'd2;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 0;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h020, d); chk("R12 ppc stat", d, 0);
    rd(12'h028, d); chk("R12 ppc en", d, 0);
    rd(12'h038, d); chk("R12 msc en", d, 0);
    rd(12'h048, d); chk("R12 brg en", d, 0);
    chk("R12 outputs", {apb_clr, apb_en, apbx_clr, apbx_en, ahbx_clr, ahbx_en, msc_clr, 3'b0, msc_irq}, 0);
  endtask

  task automatic t_mpc();
    logic [31:0] d;
    @(negedge clk); mpc = 4'b1010; mpcx = 4'b0110;
    rd(12'h01C, d); chk("R1 mpc placement", d, 32'h0006_000A);
    wr(12'h01C, 32'h0);
    rd(12'h01C, d); chk("R10 mpc stat write ignored", d, 32'h0006_000A);
    @(negedge clk); mpc = 0; mpcx = 0;
    rd(12'h01E, d); chk("R1 mpc follows level", d, 0);
  endtask

  task automatic t_ppc();
    logic [31:0] d;
    @(negedge clk); apb = 2'b10; apbx = 4'b0100; ahbx = 4'b1000;
    @(negedge clk); apb = 0; apbx = 0; ahbx = 0;
    rd(12'h020, d); chk("R2 sticky placement", d, 32'h0080_0042);
    chk("R5 clr lines", {apb_clr, apbx_clr, ahbx_clr}, {2'b10, 4'b0100, 4'b1000});
    wr(12'h020, 32'h0);
    rd(12'h020, d); chk("R10 ppc stat write ignored", d, 32'h0080_0042);
    rd(12'h024, d); chk("R10 clear reads zero", d, 0);
    wr(12'h024, 32'h0000_0040);
    rd(12'h020, d); chk("R3 w1c single", d, 32'h0080_0002);
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h020, d); chk("R3 w1c all", d, 0);
    chk("R5 clr lines low", {apb_clr, apbx_clr, ahbx_clr}, 0);
    @(negedge clk);
    apb = 2'b10; addr = 12'h024; wdata = 32'h2; size = 2'd2; we = 1;
    @(negedge clk);
    apb = 0; we = 0;
    rd(12'h020, d); chk("R3 set beats clear", d, 32'h0000_0002);
    wr(12'h024, 32'h2);
  endtask

  task automatic t_ppc_en();
    logic [31:0] d;
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h028, d); chk("R4 enable mask", d, 32'h00F0_00F3);
    chk("R5 en lines", {apb_en, apbx_en, ahbx_en}, 10'h3FF);
    wr(12'h028, 32'h0010_0020);
    chk("R5 en one each", {apb_en, apbx_en, ahbx_en}, {2'b00, 4'b0010, 4'b0001});
    wr(12'h028, 32'h0, 2'd0);
    rd(12'h028, d); chk("R11 byte write ignored", d, 32'h0010_0020);
  endtask

  task automatic t_msc();
    logic [31:0] d;
    wr(12'h038, 32'hFFFF_FFFF);
    rd(12'h038, d); chk("R6 msc en mask", d, 32'h000F_0000);
    chk("R7 irq idle", {31'b0, msc_irq}, 0);
    @(negedge clk); msc = 4'b0100;
    @(negedge clk);
    chk("R7 irq asserted", {31'b0, msc_irq}, 1);
    rd(12'h030, d); chk("R6 msc status", d, 32'h0004_0000);
    wr(12'h038, 32'h000B_0000);
    chk("R7 irq masked", {31'b0, msc_irq}, 0);
    @(negedge clk); msc = 0;
    wr(12'h034, 32'h000A_0005);
    chk("R8 clr lines", {28'b0, msc_clr}, 32'hA);
    rd(12'h034, d); chk("R8 clr reads zero", d, 0);
    wr(12'h034, 32'h000F_0000, 2'd1);
    chk("R11 half write ignored", {28'b0, msc_clr}, 32'hA);
    wr(12'h034, 32'h0);
    chk("R8 clr lines drop", {28'b0, msc_clr}, 0);
  endtask

  task automatic t_bridge();
    logic [31:0] d;
    rd(12'h040, d); chk("R9 bridge stat zero", d, 0);
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h048, d); chk("R9 bridge en mask", d, 32'hFFFF_0000);
    wr(12'h044, 32'hFFFF_FFFF);
    rd(12'h048, d); chk("R9 bridge clr no effect", d, 32'hFFFF_0000);
    rd(12'h044, d); chk("R10 bridge clr reads zero", d, 0);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    wr(12'h100, 32'h1234_5678);
    rd(12'h100, d); chk("R10 undefined reads zero", d, 0);
    rd(12'h028, d); chk("R10 undefined write no effect", d, 32'h0010_0020);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mpc();
    t_ppc();
    t_ppc_en();
    t_msc();
    t_bridge();
    t_undef();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule